// File: doc/BRIEF.md
# Accuracy-Configurable Timing Error Filter

This block sits beside a 32-bit single-precision floating-point pipeline and decides what a set of per-bit timing-error flags should lead to. When an operation is issued, the block records two things with it: whether the operation runs in exact or relaxed mode, and the current relaxation depth N. When that operation reaches the end of the pipeline, the sensors report one flag for each result bit. A flag that counts raises a replay request to the recovery logic. In relaxed mode, a flag on one of the N lowest fraction bits is discarded and reported as a masked error instead.

The depth N is held in a small configuration register, written at run time and saturated to the fraction width. The sign bit and the exponent bits are never relaxed. Each operation carries its own mode, so exact and relaxed work can alternate from one issue slot to the next. A change to the mode or to N never reaches operations that are already in flight. A sticky bit records that some error has been masked. Software reads it from the same register, and the read clears it.

Top module: `ace_err_filter`

## Requirements
- R1: After reset, replay_req and err_masked are low, and cfg_rdata reads 0 (depth 0, sticky clear).
- R2: For a retiring operation issued in exact mode, any flagged bit of sense_err raises replay_req, and err_masked stays low.
- R3: For a retiring operation issued in relaxed mode with depth N, a flag on bits [N-1:0] does not raise replay_req. If such a flag is present, err_masked is raised instead.
- R4: A flag on the sign bit [31] or on any exponent bit [30:23] of a retiring operation always raises replay_req, whatever the mode and N.
- R5: In relaxed mode, a flag on a fraction bit at position N or above (bits [22:N]) still raises replay_req.
- R6: A write of cfg_wdata sets N to that value. A value above 23 is stored as 23. N reads back on cfg_rdata[4:0].
- R7: The mode and N used to filter an operation are the values present when it issued (op_issue high), including when either changes on the very next cycle.
- R8: Flags are evaluated only when an operation retires, which is PIPE_D-1 cycles after the edge that samples op_issue. In any other cycle, both outputs stay low whatever sense_err carries.
- R9: cfg_rdata[7] is a sticky bit. It is set on the edge after err_masked is high, and it is cleared by a cycle with cfg_rd high. A masked error in the same cycle as the read keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_issue | input | 1 | An operation enters the pipeline this cycle |
| op_approx | input | 1 | Mode of the issuing operation: 1 relaxed, 0 exact |
| sense_err | input | 32 | Per-bit timing-error flags for the retiring result |
| cfg_wr | input | 1 | Write strobe for the depth register |
| cfg_wdata | input | 8 | Requested depth N |
| cfg_rd | input | 1 | Read strobe; clears the sticky bit |
| cfg_rdata | output | 8 | {sticky, 2'b0, N} |
| replay_req | output | 1 | The retiring operation must be replayed |
| err_masked | output | 1 | The retiring operation had only relaxed-bit errors ignored |

## Verification
The assertions assume the sensors present flags for a retiring result in the same cycle that the operation leaves the last pipeline stage. They also assume that cfg_wr and cfg_rd are ordinary strobes with no further protocol. The stimulus respects this timing by driving sense_err every cycle and letting the reference model decide whether a flag belongs to a retiring operation. Flags in idle cycles are therefore deliberate noise that must be ignored. Depth writes range beyond the fraction width, and mode flips from cycle to cycle, so the latching and saturation cases occur often.

// File: rtl/ace_err_filter.sv
module ace_err_filter #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23,
  parameter int PIPE_D = 4,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_issue,
  input  logic              op_approx,
  input  logic [DATA_W-1:0] sense_err,
  input  logic              cfg_wr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_rd,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic              replay_req,
  output logic              err_masked
);
  localparam int NB = $clog2(FRAC_W + 1);

  logic [NB-1:0]     n_reg;
  logic              sticky;
  logic [PIPE_D-1:0] v_pipe, a_pipe;
  logic [NB-1:0]     n_pipe [PIPE_D];

  logic              ret_valid, ret_approx;
  logic [DATA_W-1:0] relax_mask, kept, dropped;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_reg <= '0;
    end else if (cfg_wr) begin
      if (cfg_wdata > CFG_W'(FRAC_W)) n_reg <= NB'(FRAC_W);
      else                            n_reg <= cfg_wdata[NB-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_pipe <= '0;
      a_pipe <= '0;
      for (int i = 0; i < PIPE_D; i++) n_pipe[i] <= '0;
    end else begin
      v_pipe[0] <= op_issue;
      a_pipe[0] <= op_approx;
      n_pipe[0] <= n_reg;
      for (int i = 1; i < PIPE_D; i++) begin
        v_pipe[i] <= v_pipe[i-1];
        a_pipe[i] <= a_pipe[i-1];
        n_pipe[i] <= n_pipe[i-1];
      end
    end
  end

  assign ret_valid  = v_pipe[PIPE_D-1];
  assign ret_approx = a_pipe[PIPE_D-1];
  assign relax_mask = ret_approx ? ((DATA_W'(1) << n_pipe[PIPE_D-1]) - DATA_W'(1)) : '0;
  assign kept       = sense_err & ~relax_mask;
  assign dropped    = sense_err & relax_mask;

  assign replay_req = ret_valid & (|kept);
  assign err_masked = ret_valid & (|dropped);

  always_ff @(posedge clk) begin
    if (!rst_n) sticky <= 1'b0;
    else        sticky <= err_masked | (sticky & ~cfg_rd);
  end

  assign cfg_rdata = {sticky, (CFG_W-1-NB)'(0), n_reg};
endmodule

module ace_err_filter_chk #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 23,
  parameter int NB     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic              ret_approx,
  input logic [DATA_W-1:0] sense_err,
  input logic [NB-1:0]     n_cur,
  input logic              sticky,
  input logic              cfg_rd,
  input logic              replay_req,
  input logic              err_masked
);
  // R4
  sign_exp_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && |sense_err[DATA_W-1:FRAC_W]) |-> replay_req);
  // R2
  exact_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_approx && |sense_err) |-> (replay_req && !err_masked));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_valid |-> (!replay_req && !err_masked));
  // R6
  depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n_cur <= NB'(FRAC_W));
  // R9
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_masked |=> sticky);
  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && !err_masked) |=> !sticky);
endmodule

bind ace_err_filter ace_err_filter_chk #(
  .DATA_W(DATA_W), .FRAC_W(FRAC_W), .NB(NB)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ret_valid(v_pipe[PIPE_D-1]), .ret_approx(a_pipe[PIPE_D-1]),
  .sense_err(sense_err), .n_cur(n_reg), .sticky(sticky), .cfg_rd(cfg_rd),
  .replay_req(replay_req), .err_masked(err_masked)
);

// File: tb/ace_err_filter_test.sv
`timescale 1ns/1ps
module ace_err_filter_test;
  localparam int D = 4;
  localparam int CYCLES = 3000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_issue, op_approx, cfg_wr, cfg_rd;
  logic [31:0] sense_err;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic        replay_req, err_masked;

  always #2 clk = ~clk;

  ace_err_filter uut (
    .clk(clk), .rst_n(rst_n), .op_issue(op_issue), .op_approx(op_approx),
    .sense_err(sense_err), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd),
    .cfg_rdata(cfg_rdata), .replay_req(replay_req), .err_masked(err_masked)
  );

  typedef struct { bit v; bit a; int n; } rec_t;
  rec_t hist[$];
  int   m_n;
  bit   m_sticky;
  int   n_cmp = 0, n_bad = 0;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [31:0] pick_flags(input int c);
    int kind = $urandom_range(0, 4);
    logic [31:0] f = '0;
    if (c >= 400 && c < 600) return 32'(1) << $urandom_range(0, 22);
    if (c >= 600 && c < 700) return 32'(1) << $urandom_range(23, 31);
    case (kind)
      1: f[$urandom_range(0, 31)] = 1'b1;
      2: begin f[$urandom_range(0, 31)] = 1'b1; f[$urandom_range(0, 22)] = 1'b1; end
      3: f = $urandom() & $urandom() & $urandom();
      4: f[$urandom_range(0, 22)] = 1'b1;
      default: f = '0;
    endcase
    return f;
  endfunction

  task automatic drive(input int c);
    op_issue  = ($urandom_range(0, 3) != 0);
    op_approx = (c < 200) ? 1'b0 : (c >= 400 && c < 700) ? 1'b1 : 1'($urandom_range(0, 1));
    sense_err = pick_flags(c);
    cfg_wr    = (c >= 900 && c < 1100) ? 1'b1 : ($urandom_range(0, 7) == 0);
    cfg_wdata = (c < 400 || c >= 1800) ? 8'($urandom_range(0, 40)) : 8'($urandom_range(0, 255));
    cfg_rd    = ($urandom_range(0, 9) == 0);
  endtask

  task automatic compare();
    bit exp_rep = 0, exp_msk = 0;
    if (hist.size() == D && hist[0].v) begin
      for (int b = 0; b < 32; b++) begin
        if (sense_err[b]) begin
          if (hist[0].a && b < hist[0].n) exp_msk = 1;
          else exp_rep = 1;
        end
      end
    end
    // R2 R4 R5 R7 R8 replay decision
    check("R2/R4/R5/R7/R8 replay_req", int'(replay_req), int'(exp_rep));
    // R3 R7 R8 masked indication
    check("R3/R7/R8 err_masked", int'(err_masked), int'(exp_msk));
    // R6 R9 register readback
    check("R6/R9 cfg_rdata", int'(cfg_rdata), (int'(m_sticky) << 7) | m_n);
    if (exp_msk) m_sticky = 1;
    else if (cfg_rd) m_sticky = 0;
  endtask

  task automatic model_step();
    rec_t r;
    r.v = op_issue; r.a = op_approx; r.n = m_n;
    hist.push_back(r);
    if (hist.size() > D) void'(hist.pop_front());
    if (cfg_wr) m_n = (cfg_wdata > 23) ? 23 : int'(cfg_wdata);
  endtask

  initial begin
    #(4ns * 20000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_issue = 0; op_approx = 0; sense_err = '1;
    cfg_wr = 0; cfg_wdata = 0; cfg_rd = 0;
    m_n = 0; m_sticky = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 replay_req", int'(replay_req), 0);
    check("R1 err_masked", int'(err_masked), 0);
    check("R1 cfg_rdata", int'(cfg_rdata), 0);
    rst_n = 1'b1;
    for (int c = 0; c < CYCLES; c++) begin
      @(posedge clk);
      #1 drive(c);
      #1 compare();
      model_step();
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule